// File: doc/BRIEF.md
# Converter serial port with end-of-conversion busy flag

This block models the digital side of a successive-approximation converter's serial port. A rising edge on `cnv` starts a conversion that lasts a fixed number of system clock cycles. While the port is running, a 14-bit configuration word can be clocked in on `din` and the previous result clocked out on `sdo`. The conversion result itself is not computed: the word on `sample_data` is captured when the conversion starts and is combined with the channel field of the configuration that was in force for that conversion.

All changes to the configuration and to the output word happen at the end-of-conversion instant (EOC). At EOC the port can flag completion by pulling `sdo` low for one cycle. The flag is produced only if `cnv` is low at that instant and the line is either released or still holds a high bit from the previous frame. The line is released after one falling edge more than the frame holds. `sck`, `cnv` and `din` are taken as synchronous to `clk` and are sampled on its rising edge. An SCK edge is the change seen between two samples.

Top module: `sar_serial_port`

## Requirements
- R1: A rising edge of `cnv` seen while no conversion is running starts one. EOC follows exactly `CONV_CYCLES` clock edges later. A further `cnv` rising edge during a conversion neither restarts it nor recaptures `sample_data`.
- R2: The configuration word is shifted in on `din`, MSB first, on SCK rising edges. Bits [13:11] hold the channel and bit 0 holds the readback enable. Once 14 bits have been received, any further rising edges before the next EOC are ignored.
- R3: A configuration word takes effect only at EOC. If fewer than 14 bits arrived since the previous EOC, the partial word is discarded and the configuration in force is kept.
- R4: The frame loaded at the EOC of conversion k holds a 16-bit result. Its bits [15:13] are the channel of the configuration in force when conversion k started, XOR `sample_data[15:13]`. Its bits [12:0] are `sample_data[12:0]`, captured when conversion k started. A word written before EOC k-1 therefore first appears in the frame read after EOC k.
- R5: The results of the first three conversions after reset read as `UNDEF_WORD` (default zero).
- R6: If `cnv` is low at EOC and `sdo_oe` is low or `sdo` is high, `sdo` is driven low for exactly one cycle. The frame MSB follows in the next cycle.
- R7: If `cnv` is high at EOC, no busy flag is produced. `sdo` and `sdo_oe` keep their values until `cnv` is low. One cycle after that, the frame MSB is driven.
- R8: If `cnv` is low at EOC while the line still drives a low bit, no busy flag is produced. The frame MSB is driven in the cycle after EOC.
- R9: Each SCK falling edge advances the frame by one bit. With readback off, the LSB of the 16-bit result appears after 15 falling edges and is held on the 16th. The line is released on the 17th.
- R10: If the configuration in force for a conversion has readback enabled, its frame is 30 bits: the result followed by that 14-bit configuration. It is released on the 31st falling edge.
- R11: After reset, `sdo_oe` is low, the configuration is all zeros and no conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv | input | 1 | Conversion start (rising edge) and output gate |
| sck | input | 1 | Serial clock, sampled by `clk` |
| din | input | 1 | Configuration data in |
| sample_data | input | 16 | Stand-in conversion value |
| sdo | output | 1 | Serial data and busy flag |
| sdo_oe | output | 1 | Drive enable of `sdo` (low means released) |

## Verification
The properties assume that each level of `sck` lasts at least one clock period and that a rise and a fall are never seen at the same clock edge. They also assume that no SCK edge coincides with EOC or with the one-cycle busy flag. The stimulus keeps to this by toggling `sck` only on falling clock edges with two cycles per bit. Each readout starts only after the cycle that follows EOC, and `cnv` is kept still around EOC except in the deliberate retrigger case.

// File: rtl/sarp_pkg.sv
package sarp_pkg;

    localparam int DATA_W    = 16;
    localparam int CFG_W     = 14;
    localparam int CH_W      = 3;
    localparam int FRAME_W   = DATA_W + CFG_W;
    localparam int FCNT_W    = $clog2(FRAME_W + 2);
    localparam int CFG_CNT_W = $clog2(CFG_W + 1);

    typedef struct packed {
        logic [CH_W-1:0]         chan;
        logic [CFG_W-CH_W-2:0]   spare;
        logic                    rb_en;
    } cfg_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_BUSY,
        TX_WAIT,
        TX_DRIVE
    } tx_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [FCNT_W-1:0]  len;
    } frame_t;

    function automatic logic [DATA_W-1:0] make_result(cfg_t c, logic [DATA_W-1:0] s);
        return {c.chan ^ s[DATA_W-1:DATA_W-CH_W], s[DATA_W-CH_W-1:0]};
    endfunction

    function automatic frame_t make_frame(cfg_t c, logic [DATA_W-1:0] r);
        frame_t f;
        f.bits = c.rb_en ? {r, c} : {r, {CFG_W{1'b0}}};
        f.len  = c.rb_en ? FCNT_W'(FRAME_W) : FCNT_W'(DATA_W);
        return f;
    endfunction

endpackage

// File: rtl/sarp_conv_timer.sv
module sarp_conv_timer #(
    parameter int CONV_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic cnv,
    output logic start,
    output logic eoc
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    logic             cnv_prev;
    logic             running;
    logic [CNT_W-1:0] remain;

    assign start = cnv && !cnv_prev && !running;
    assign eoc   = running && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnv_prev <= 1'b0;
            running  <= 1'b0;
            remain   <= '0;
        end else begin
            cnv_prev <= cnv;
            if (start) begin
                running <= 1'b1;
                remain  <= CNT_W'(CONV_CYCLES - 1);
            end else if (running) begin
                if (remain == '0) running <= 1'b0;
                else              remain  <= remain - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sarp_cfg_rx.sv
module sarp_cfg_rx
    import sarp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sck_rise,
    input  logic din,
    input  logic eoc,
    output cfg_t active
);
    logic [CFG_W-1:0]     shreg;
    logic [CFG_CNT_W-1:0] nbits;
    logic                 full;

    assign full = (nbits == CFG_CNT_W'(CFG_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            nbits  <= '0;
            active <= '0;
        end else if (eoc) begin
            if (full) active <= cfg_t'(shreg);
            nbits <= '0;
        end else if (sck_rise && !full) begin
            shreg <= {shreg[CFG_W-2:0], din};
            nbits <= nbits + CFG_CNT_W'(1);
        end
    end
endmodule

// File: rtl/sarp_sdo_tx.sv
module sarp_sdo_tx
    import sarp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      eoc,
    input  logic      cnv,
    input  logic      sck_fall,
    input  frame_t    frame_in,
    output logic      sdo,
    output logic      sdo_oe,
    output tx_state_e state
);
    logic [FRAME_W-1:0] shreg;
    logic [FCNT_W-1:0]  len;
    logic [FCNT_W-1:0]  falls;
    logic               oe_r;
    logic               bit_r;

    assign sdo    = bit_r;
    assign sdo_oe = oe_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            shreg <= '0;
            len   <= '0;
            falls <= '0;
            oe_r  <= 1'b0;
            bit_r <= 1'b0;
        end else if (eoc) begin
            shreg <= frame_in.bits;
            len   <= frame_in.len;
            falls <= '0;
            if (cnv) begin
                state <= TX_WAIT;
            end else if (!oe_r || bit_r) begin
                state <= TX_BUSY;
                oe_r  <= 1'b1;
                bit_r <= 1'b0;
            end else begin
                state <= TX_DRIVE;
                oe_r  <= 1'b1;
                bit_r <= frame_in.bits[FRAME_W-1];
            end
        end else begin
            case (state)
                TX_BUSY: begin
                    state <= TX_DRIVE;
                    bit_r <= shreg[FRAME_W-1];
                end
                TX_WAIT: begin
                    if (!cnv) begin
                        state <= TX_DRIVE;
                        oe_r  <= 1'b1;
                        bit_r <= shreg[FRAME_W-1];
                    end
                end
                TX_DRIVE: begin
                    if (sck_fall) begin
                        falls <= falls + FCNT_W'(1);
                        if (falls == len) begin
                            state <= TX_IDLE;
                            oe_r  <= 1'b0;
                            bit_r <= 1'b0;
                        end else if ((falls + FCNT_W'(1)) < len) begin
                            shreg <= shreg << 1;
                            bit_r <= shreg[FRAME_W-2];
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
    import sarp_pkg::*;
#(
    parameter int                CONV_CYCLES   = 20,
    parameter int                UNDEF_RESULTS = 3,
    parameter logic [DATA_W-1:0] UNDEF_WORD    = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv,
    input  logic              sck,
    input  logic              din,
    input  logic [DATA_W-1:0] sample_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int UCNT_W = $clog2(UNDEF_RESULTS + 2);

    logic              sck_prev;
    logic              sck_rise;
    logic              sck_fall;
    logic              start;
    logic              eoc;
    cfg_t              active_cfg;
    cfg_t              conv_cfg;
    logic [DATA_W-1:0] sample_q;
    logic [UCNT_W-1:0] ndone;
    logic [DATA_W-1:0] result;
    frame_t            frame;
    tx_state_e         tx_state;

    assign sck_rise = sck && !sck_prev;
    assign sck_fall = !sck && sck_prev;

    sarp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .cnv   (cnv),
        .start (start),
        .eoc   (eoc)
    );

    sarp_cfg_rx u_cfg (
        .clk      (clk),
        .rst      (rst),
        .sck_rise (sck_rise),
        .din      (din),
        .eoc      (eoc),
        .active   (active_cfg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            conv_cfg <= '0;
            sample_q <= '0;
            ndone    <= '0;
        end else begin
            sck_prev <= sck;
            if (start) begin
                conv_cfg <= active_cfg;
                sample_q <= sample_data;
            end
            if (eoc && (ndone < UCNT_W'(UNDEF_RESULTS))) ndone <= ndone + UCNT_W'(1);
        end
    end

    always_comb begin
        result = (ndone < UCNT_W'(UNDEF_RESULTS)) ? UNDEF_WORD : make_result(conv_cfg, sample_q);
        frame  = make_frame(conv_cfg, result);
    end

    sarp_sdo_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .eoc      (eoc),
        .cnv      (cnv),
        .sck_fall (sck_fall),
        .frame_in (frame),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .state    (tx_state)
    );
endmodule

// File: rtl/sarp_checker.sv
module sarp_checker
    import sarp_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      cnv,
    input logic      sck_fall,
    input logic      eoc,
    input cfg_t      active_cfg,
    input tx_state_e tx_state,
    input logic      sdo,
    input logic      sdo_oe
);
    assert_eoc_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !eoc)
        else $error("EOC lasted more than one cycle");

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !eoc |=> $stable(active_cfg))
        else $error("configuration changed away from EOC");

    assert_busy_origin_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_state == TX_BUSY) |-> $past(eoc && !cnv))
        else $error("busy flag without EOC at low cnv");

    assert_no_busy_cnv_high_R7: assert property (@(posedge clk) disable iff (rst)
        (eoc && cnv) |=> ($stable(sdo_oe) && $stable(sdo)))
        else $error("line moved at EOC with cnv high");

    assert_low_bit_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (eoc && !cnv && sdo_oe && !sdo) |=> (tx_state == TX_DRIVE))
        else $error("busy flag after a low leftover bit");

    assert_oe_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && !sck_fall && !eoc) |=> sdo_oe)
        else $error("line released without a falling SCK edge");
endmodule

bind sar_serial_port sarp_checker u_sarp_checker (
    .clk        (clk),
    .rst        (rst),
    .cnv        (cnv),
    .sck_fall   (sck_fall),
    .eoc        (eoc),
    .active_cfg (active_cfg),
    .tx_state   (tx_state),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
);

// File: tb/test_sar_serial_port.sv
module test_sar_serial_port;
    localparam int CONV = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnv = 1'b0;
    logic        sck = 1'b0;
    logic        din = 1'b0;
    logic [15:0] sample_data = '0;
    logic        sdo;
    logic        sdo_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench-side model
    logic [13:0] act_cfg_m  = '0;
    logic [13:0] pend_m     = '0;
    logic [13:0] conv_cfg_m = '0;
    bit          pend_full  = 0;
    bit          drop_now   = 0;
    bit          drop_d     = 0;
    bit          conv_partial = 0;
    bit          conv_retrig  = 0;
    bit          cur_undef  = 0;
    bit          cur_rb     = 0;
    int          ndone      = 0;
    logic [15:0] exp_res;
    logic [29:0] exp_frame;
    int          exp_len    = 16;
    bit          line_oe    = 0;
    bit          line_bit   = 0;

    always #4 clk = ~clk;

    sar_serial_port #(.CONV_CYCLES(CONV)) i_sar_serial_port (
        .clk         (clk),
        .rst         (rst),
        .cnv         (cnv),
        .sck         (sck),
        .din         (din),
        .sample_data (sample_data),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_conv(input logic [15:0] samp, input bit hold_high, input bit retrig);
        bit msb;
        sample_data  = samp;
        conv_cfg_m   = act_cfg_m;
        conv_partial = drop_d;
        conv_retrig  = retrig;
        cnv = 1'b1;
        tick(1);
        if (!hold_high) cnv = 1'b0;
        if (retrig) begin
            tick(CONV / 2);
            cnv = 1'b1;
            sample_data = ~samp;
            tick(1);
            cnv = 1'b0;
            tick(CONV - CONV / 2 - 2);
        end else begin
            tick(CONV - 1);
        end
        chk(sdo_oe == line_oe && (!line_oe || sdo == line_bit), "R1 line unchanged before EOC",
            {30'd0, sdo_oe, sdo}, {30'd0, line_oe, line_bit});
        tick(1);
        // model of EOC
        cur_undef = (ndone < 3);
        exp_res   = cur_undef ? 16'h0000 : {conv_cfg_m[13:11] ^ samp[15:13], samp[12:0]};
        cur_rb    = conv_cfg_m[0];
        exp_len   = cur_rb ? 30 : 16;
        exp_frame = cur_rb ? {exp_res, conv_cfg_m} : {exp_res, 14'h0000};
        if (pend_full) act_cfg_m = pend_m;
        pend_full = 0;
        drop_d    = drop_now;
        drop_now  = 0;
        ndone++;
        msb = exp_frame[29];
        if (hold_high) begin
            chk(sdo_oe == line_oe && (!line_oe || sdo == line_bit), "R7 no flag with cnv high",
                {30'd0, sdo_oe, sdo}, {30'd0, line_oe, line_bit});
            tick(2);
            chk(sdo_oe == line_oe && (!line_oe || sdo == line_bit), "R7 line waits for cnv low",
                {30'd0, sdo_oe, sdo}, {30'd0, line_oe, line_bit});
            cnv = 1'b0;
            tick(1);
            chk(sdo_oe && sdo == msb, "R7 MSB after cnv low", {30'd0, sdo_oe, sdo}, {30'd0, 1'b1, msb});
        end else if (!line_oe || line_bit) begin
            chk(sdo_oe && !sdo, "R6 busy flag low", {30'd0, sdo_oe, sdo}, {30'd0, 2'b10});
            tick(1);
            chk(sdo_oe && sdo == msb, "R6 MSB after flag", {30'd0, sdo_oe, sdo}, {30'd0, 1'b1, msb});
        end else begin
            chk(sdo_oe && sdo == msb, "R8 MSB with no flag", {30'd0, sdo_oe, sdo}, {30'd0, 1'b1, msb});
        end
    endtask

    task automatic read_frame(input int nf, input logic [13:0] wcfg);
        logic [31:0] got;
        logic [31:0] want;
        bit          oe_ok;
        string       tag;
        int          last;
        got = '0;
        want = '0;
        oe_ok = 1;
        for (int i = 0; i < nf; i++) begin
            int idx;
            idx  = (i < exp_len - 1) ? i : exp_len - 1;
            got  = {got[30:0], sdo};
            want = {want[30:0], exp_frame[29 - idx]};
            if (!sdo_oe) oe_ok = 0;
            din = (i < 14) ? wcfg[13 - i] : 1'b1;
            sck = 1'b1;
            tick(1);
            sck = 1'b0;
            tick(1);
        end
        if (cur_undef)   tag = "R5 undefined result frame";
        else if (cur_rb) tag = "R10 readback frame R2";
        else             tag = "R4 result frame R2";
        if (conv_partial) tag = {tag, " R3 partial word dropped"};
        if (conv_retrig)  tag = {tag, " R1 retrigger ignored"};
        chk(oe_ok && got == want, tag, got, want);
        if (nf >= 14) begin
            pend_m = wcfg;
            pend_full = 1;
        end else if (nf > 0) begin
            drop_now = 1;
        end
        if (nf == exp_len + 1) begin
            chk(!sdo_oe, cur_rb ? "R10 released on 31st fall" : "R9 released on 17th fall",
                {31'd0, sdo_oe}, 32'd0);
            line_oe = 0;
        end else begin
            last = (nf < exp_len - 1) ? nf : exp_len - 1;
            line_oe  = 1;
            line_bit = exp_frame[29 - last];
            if (nf == exp_len)
                chk(sdo_oe && sdo == line_bit, cur_rb ? "R10 last bit held" : "R9 LSB held",
                    {30'd0, sdo_oe, sdo}, {30'd0, 1'b1, line_bit});
        end
    endtask

    initial begin
        logic [13:0] fixed_cfg;
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        chk(!sdo_oe, "R11 released at reset", {31'd0, sdo_oe}, 32'd0);
        tick(2);
        chk(!sdo_oe, "R11 released while idle", {31'd0, sdo_oe}, 32'd0);

        for (int p = 0; p < 12; p++) begin
            logic [13:0] wcfg;
            int          nf;
            wcfg = {3'((p * 3 + 1) % 8), 10'(p * 37), (p % 3 == 1)};
            run_conv(16'hA5C3 ^ 16'(p * 16'h1F3B), (p % 5 == 2), 1'b0);
            if (p == 6)           nf = 10;
            else if (p % 4 == 3)  nf = exp_len;
            else                  nf = exp_len + 1;
            read_frame(nf, wcfg);
        end

        fixed_cfg = {3'd4, 10'd0, 1'b0};
        run_conv(16'h3C5A, 1'b0, 1'b0);
        read_frame(exp_len + 1, fixed_cfg);
        run_conv(16'h5A3C, 1'b0, 1'b0);
        read_frame(exp_len + 1, fixed_cfg);
        run_conv(16'h0002, 1'b0, 1'b0);     // LSB low left on the line
        read_frame(exp_len, fixed_cfg);
        run_conv(16'h0001, 1'b0, 1'b0);     // R8 path, LSB high left on the line
        read_frame(exp_len, fixed_cfg);
        run_conv(16'h1234, 1'b0, 1'b1);     // R6 path with retrigger
        read_frame(exp_len + 1, fixed_cfg);

        tick(4);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule